// File: doc/BRIEF.md
# Sticky Interrupt Flag Register with Two-Line Routing

This block collects 24 event conditions into a 32-bit status register of sticky flags. A flag latches when its event input goes from low to high. It stays latched until the host writes a one to its bit position. A hard reset is the only other way to clear it.

Two further 32-bit read/write registers sit beside the flags. The enable register decides whether a latched flag raises an interrupt at all. The line-select register sends each enabled flag to one of two interrupt outputs. Each output is the registered OR of every flag that is set, enabled and routed to it, so the outputs do not glitch.

The host reaches the three registers through a 2-bit address with separate write and read strobes. A read captures the addressed register into a holding register on the strobe edge. The table below uses `flags` for address 0, `enable` for address 1 and `select` for address 2. Address 3 reads as zero and ignores writes.

Top module: `irq_flags_top`

## Requirements
- R1: Flag bit i is set at a clock edge where evtIn[i] is 1 and was 0 at the previous edge. An event held high does not set the flag again after it has been cleared.
- R2: A set flag stays set across any number of cycles until the host clears it or reset is applied.
- R3: A write to address 0 clears every flag whose data bit is 1. Data bits of 0 leave their flags unchanged.
- R4: Asserting rstN low clears the flags, the enable and select registers, the read data and both interrupt lines.
- R5: A flag whose enable bit (address 1, bit i) is 0 drives neither interrupt line.
- R6: A set, enabled flag drives irqLine0 when its select bit (address 2, bit i) is 0, and irqLine1 when the select bit is 1.
- R7: Bits 31:24 of address 0 always read as zero. Writes to those bits have no effect.
- R8: If a rising event edge and a write-1 clear of the same flag land at the same edge, the flag ends up set.
- R9: The interrupt lines are registered. They change one clock edge after the flag, enable or select state that causes the change.
- R10: The enable and select registers store and read back all 32 bits written. Address 3 reads as zero.
- R11: regRdData loads the addressed register at an edge where regRdEn is 1. At all other edges it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hard reset, active low |
| evtIn | input | 24 | Event conditions, one per flag |
| regAddr | input | 2 | Register address: 0 flags, 1 enable, 2 select, 3 none |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Registered read data |
| irqLine0 | output | 1 | Interrupt line 0 |
| irqLine1 | output | 1 | Interrupt line 1 |

## Verification
An event level sampled at edge k sets its flag at edge k. The interrupt line for that flag follows at edge k+1. A write to the enable or select register moves the lines one edge after the write edge. A read strobe at edge k presents data after edge k.

The bench drives every input at the falling edge and samples at the next falling edge. It steps exactly one rising edge for each register stage on the path, so each check lands on the first cycle its result is due. For the interrupt line, it also checks the cycle just before the result is due, which confirms the line is registered.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ADDR_FLAGS  = 2'd0,
    ADDR_ENABLE = 2'd1,
    ADDR_SELECT = 2'd2,
    ADDR_NONE   = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic     clrFlags;
    logic     wrEnable;
    logic     wrSelect;
    logic     rdLoad;
    regAddr_e rdSel;
  } busStrobe_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic       [1:0] regAddr,
  input  logic             regWrEn,
  input  logic             regRdEn,
  output busStrobe_t       strobe
);
  regAddr_e addrDec;

  always_comb begin
    addrDec         = regAddr_e'(regAddr);
    strobe.clrFlags = regWrEn && (addrDec == ADDR_FLAGS);
    strobe.wrEnable = regWrEn && (addrDec == ADDR_ENABLE);
    strobe.wrSelect = regWrEn && (addrDec == ADDR_SELECT);
    strobe.rdLoad   = regRdEn;
    strobe.rdSel    = addrDec;
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_FLAGS = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] evtIn,
  input  busStrobe_t           strobe,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqLine0,
  output logic                 irqLine1
);
  logic [NUM_FLAGS-1:0] evtPrev;
  logic [NUM_FLAGS-1:0] flagReg;
  logic [NUM_FLAGS-1:0] flagNext;
  logic [DATA_W-1:0]    enReg;
  logic [DATA_W-1:0]    selReg;
  logic [DATA_W-1:0]    rdNext;
  logic [NUM_FLAGS-1:0] toLine0;
  logic [NUM_FLAGS-1:0] toLine1;

  // one cell per flag: edge detect, then set dominates clear
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic riseSeen;
    logic clrHit;
    assign riseSeen    = evtIn[i] & ~evtPrev[i];
    assign clrHit      = strobe.clrFlags & wrData[i];
    assign flagNext[i] = riseSeen | (flagReg[i] & ~clrHit);
    assign toLine0[i]  = flagReg[i] & enReg[i] & ~selReg[i];
    assign toLine1[i]  = flagReg[i] & enReg[i] &  selReg[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtPrev <= '0;
      flagReg <= '0;
    end else begin
      evtPrev <= evtIn;
      flagReg <= flagNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= '0;
      selReg <= '0;
    end else begin
      if (strobe.wrEnable) enReg  <= wrData;
      if (strobe.wrSelect) selReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqLine0 <= 1'b0;
      irqLine1 <= 1'b0;
    end else begin
      irqLine0 <= |toLine0;
      irqLine1 <= |toLine1;
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (strobe.rdSel)
      ADDR_FLAGS:  rdNext[NUM_FLAGS-1:0] = flagReg;
      ADDR_ENABLE: rdNext = enReg;
      ADDR_SELECT: rdNext = selReg;
      default:     rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdData <= '0;
    else if (strobe.rdLoad) rdData <= rdNext;
  end

  // R1: a flag that newly appears had its event high at that edge
  a_r1_new_flag_needs_event: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagReg & ~$past(flagReg) & ~$past(evtIn)) == '0));

  // R2: without a clear strobe no flag drops
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrFlags |=> ((flagReg & $past(flagReg)) == $past(flagReg)));

  // R3: written ones clear their flags unless an event is present
  a_r3_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrFlags |=> ((flagReg & $past(wrData[NUM_FLAGS-1:0]) & ~$past(evtIn)) == '0));

  // R5: nothing enabled means both lines low next cycle
  a_r5_gated: assert property (@(posedge clk) disable iff (!rstN)
    ((flagReg & enReg[NUM_FLAGS-1:0]) == '0) |=> (!irqLine0 && !irqLine1));

  // R6: nothing routed to line 0 keeps it low
  a_r6_route0: assert property (@(posedge clk) disable iff (!rstN)
    ((flagReg & enReg[NUM_FLAGS-1:0] & ~selReg[NUM_FLAGS-1:0]) == '0) |=> !irqLine0);

  // R7: reserved readback bits stay zero for the flag address
  a_r7_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdLoad && strobe.rdSel == ADDR_FLAGS) |=> (rdData[DATA_W-1:NUM_FLAGS] == '0));

  // R11: read data holds without a read strobe
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdLoad |=> $stable(rdData));
endmodule

// File: rtl/irq_flags_top.sv
module irq_flags_top
  import irq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_FLAGS = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] evtIn,
  input  logic [1:0]           regAddr,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 irqLine0,
  output logic                 irqLine1
);
  busStrobe_t strobe;

  irq_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strobe  (strobe)
  );

  irq_datapath #(
    .DATA_W    (DATA_W),
    .NUM_FLAGS (NUM_FLAGS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .evtIn    (evtIn),
    .strobe   (strobe),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .irqLine0 (irqLine0),
    .irqLine1 (irqLine1)
  );
endmodule

// File: tb/tb_irq_flags_top.sv
module tb_irq_flags_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] evtIn = '0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqLine0;
  logic        irqLine1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_flags_top dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqLine0(irqLine0), .irqLine1(irqLine1)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] addr, logic [31:0] data);
    regAddr = addr; regWrData = data; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(logic [1:0] addr, output logic [31:0] data);
    regAddr = addr; regRdEn = 1'b1;
    tick();
    regRdEn = 1'b0;
    data = regRdData;
  endtask

  task automatic pulse(logic [23:0] bits);
    evtIn = evtIn | bits;
    tick();
    evtIn = evtIn & ~bits;
    tick();
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R4 rdData", regRdData, 32'h0);
    check("R4 lines", {30'h0, irqLine1, irqLine0}, 32'h0);
    regRead(2'd0, v); check("R4 flags", v, 32'h0);
    regRead(2'd1, v); check("R4 enable", v, 32'h0);
    regRead(2'd2, v); check("R4 select", v, 32'h0);
  endtask

  task automatic testEdge();
    logic [31:0] v;
    pulse(24'h000008);
    repeat (3) tick();
    regRead(2'd0, v); check("R1 R2 pulse sets and sticks", v, 32'h8);
    evtIn[5] = 1'b1;
    tick();
    regWrite(2'd0, 32'h20);
    repeat (2) tick();
    regRead(2'd0, v); check("R1 held level no reset", v, 32'h8);
    evtIn[5] = 1'b0;
    tick();
  endtask

  task automatic testClear();
    logic [31:0] v;
    regWrite(2'd0, 32'h0);
    regRead(2'd0, v); check("R3 write zero no effect", v, 32'h8);
    regWrite(2'd0, 32'hFFFF_FFF7);
    regRead(2'd0, v); check("R3 other ones leave bit", v, 32'h8);
    regWrite(2'd0, 32'h8);
    regRead(2'd0, v); check("R3 write one clears", v, 32'h0);
  endtask

  task automatic testRoute();
    regWrite(2'd1, 32'h4);
    evtIn[2] = 1'b1;
    tick();
    evtIn[2] = 1'b0;
    check("R9 line not yet", {30'h0, irqLine1, irqLine0}, 32'h0);
    tick();
    check("R6 R9 line0", {30'h0, irqLine1, irqLine0}, 32'h1);
    regWrite(2'd2, 32'h4);
    check("R9 route before update", {30'h0, irqLine1, irqLine0}, 32'h1);
    tick();
    check("R6 line1", {30'h0, irqLine1, irqLine0}, 32'h2);
    regWrite(2'd1, 32'h0);
    tick();
    check("R5 disabled", {30'h0, irqLine1, irqLine0}, 32'h0);
    pulse(24'h000010);
    tick();
    check("R5 unenabled flag silent", {30'h0, irqLine1, irqLine0}, 32'h0);
    regWrite(2'd0, 32'h14);
    regWrite(2'd2, 32'h0);
  endtask

  task automatic testWide();
    logic [31:0] v;
    regWrite(2'd1, 32'hA5C3_0F96);
    regRead(2'd1, v); check("R10 enable 32b", v, 32'hA5C3_0F96);
    regWrite(2'd2, 32'hFFFF_FFFF);
    regRead(2'd2, v); check("R10 select 32b", v, 32'hFFFF_FFFF);
    regWrite(2'd3, 32'h1234_5678);
    regRead(2'd3, v); check("R10 addr3 zero", v, 32'h0);
    pulse(24'hFF_FFFF);
    regWrite(2'd0, 32'hFF00_0000);
    regRead(2'd0, v); check("R7 reserved zero", v, 32'h00FF_FFFF);
    regWrite(2'd0, 32'hFFFF_FFFF);
    regWrite(2'd1, 32'h0);
    regWrite(2'd2, 32'h0);
    regRead(2'd0, v); check("R3 all cleared", v, 32'h0);
  endtask

  task automatic testCollide();
    logic [31:0] v;
    pulse(24'h000080);
    regAddr = 2'd0; regWrData = 32'h80; regWrEn = 1'b1;
    evtIn[7] = 1'b1;
    tick();
    regWrEn = 1'b0; regWrData = '0; evtIn[7] = 1'b0;
    regRead(2'd0, v); check("R8 set wins over clear", v, 32'h80);
    regWrite(2'd0, 32'h80);
  endtask

  task automatic testReadHold();
    logic [31:0] v;
    regRead(2'd0, v);
    pulse(24'h000001);
    check("R11 holds without strobe", regRdData, 32'h0);
    regRead(2'd0, v); check("R11 loads on strobe", v, 32'h1);
  endtask

  task automatic testMidReset();
    regWrite(2'd1, 32'h1);
    tick();
    check("R6 pre reset line0", {30'h0, irqLine1, irqLine0}, 32'h1);
    rstN = 1'b0;
    #1;
    check("R4 lines async", {30'h0, irqLine1, irqLine0}, 32'h0);
    check("R4 rdData async", regRdData, 32'h0);
    tick();
    rstN = 1'b1;
    tick();
    testReset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    testReset();
    testEdge();
    testClear();
    testRoute();
    testWide();
    testCollide();
    testReadHold();
    testMidReset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule